// File: doc/BRIEF.md
# External Pulse Width Event Timer

This block measures how long an external input stays at a chosen level. While the timer runs, it counts system clock cycles during which the input, after a two-flop synchroniser, sits at the selected level: high or low. When that level ends, the count stops and holds the measured width. When the level starts again, the count restarts from zero, so each new pulse is measured on its own.

Software sets up the block by pulsing `cfg_wr` with three settings: enable, level select and overflow behaviour. Every such write clears the count. If the count passes its top value, the block sets a sticky overflow flag. Depending on the overflow setting, the timer then either wraps around and keeps counting, or stops with a count of zero until enable is written again. The flag stays set until `stat_rd` is pulsed. The interrupt output is the flag, masked by its enable input. All pins are plain control and status pins with no stream handshake, because the block neither takes nor emits a data stream.

Top module: `evt_pulse_timer`

## Requirements
- R1: After reset, `count_o`, `ovf_flag_o`, `irq_o` and `run_o` are all 0.
- R2: With `cfg_low_level`=0, a high pulse of N clock cycles on `ext_in` gives `count_o`=N. The count settles three clock edges after each input change: two synchroniser stages plus the count register.
- R3: With `cfg_low_level`=1, a low pulse of N clock cycles on `ext_in` gives `count_o`=N.
- R4: After the measured level ends, `count_o` holds its value for as long as the input stays at the other level.
- R5: When the selected level starts again, the count restarts at 1 on the first cycle at that level. A later pulse of M cycles therefore gives `count_o`=M, whatever the earlier count was.
- R6: A cycle with `cfg_wr`=1 clears `count_o` to 0 and sets `run_o` to `cfg_enable`. While `run_o`=0, pulses on `ext_in` leave `count_o` unchanged.
- R7: With `cfg_wrap`=1, a pulse longer than 2^COUNT_W-1 cycles wraps the count: a pulse of N cycles gives N mod 2^COUNT_W. The wrap also sets `ovf_flag_o`, and `run_o` stays 1.
- R8: With `cfg_wrap`=0, an overflow sets `count_o` to 0, clears `run_o` and sets `ovf_flag_o`. Later pulses are not counted until a `cfg_wr` with `cfg_enable`=1.
- R9: `ovf_flag_o` stays set until a cycle with `stat_rd`=1 clears it. If a new overflow happens in the same cycle as the read, the flag stays set.
- R10: `irq_o` is 1 exactly when `ovf_flag_o`=1 and `irq_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the counted unit |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_in | input | 1 | External signal to be measured (asynchronous) |
| cfg_wr | input | 1 | One-cycle strobe that loads the three settings below |
| cfg_enable | input | 1 | Setting: run the timer |
| cfg_low_level | input | 1 | Setting: 1 counts while input is low, 0 while high |
| cfg_wrap | input | 1 | Setting: 1 keeps counting on overflow, 0 stops and clears |
| irq_en | input | 1 | Overflow interrupt enable |
| stat_rd | input | 1 | One-cycle strobe that reads and clears the overflow flag |
| count_o | output | COUNT_W | Measured width in clock cycles |
| run_o | output | 1 | Timer currently running |
| ovf_flag_o | output | 1 | Sticky overflow status |
| irq_o | output | 1 | Masked overflow interrupt |

## Verification
The assertions check the per-cycle rules on every cycle. The count moves only by +1, or back to 0 or 1, and never moves while the timer is stopped. A stop without a configuration write always leaves a zero count and a set flag. The flag stays sticky until it is read, and the interrupt never fires while masked. Only the bench's scenarios can show the absolute results. Those are the measured widths for swept pulse lengths at both levels, the held value between pulses, the wrapped remainder of a long pulse, and that re-enabling after a stop brings measurement back.

// File: rtl/evt_pkg.sv
package evt_pkg;
  typedef struct packed {
    logic enable;
    logic low_level;
    logic wrap;
  } evt_cfg_t;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/evt_core.sv
module evt_core
  import evt_pkg::*;
#(
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lvl_s,
  input  logic               cfg_wr,
  input  evt_cfg_t           cfg_new,
  output logic [COUNT_W-1:0] count_o,
  output logic               run_o,
  output logic               ovf_o
);
  localparam logic [COUNT_W-1:0] CNT_MAX = {COUNT_W{1'b1}};
  localparam logic [COUNT_W-1:0] CNT_ONE = COUNT_W'(1);

  evt_cfg_t           cfg_q;
  logic               run_q;
  logic               act_d;
  logic [COUNT_W-1:0] cnt_q;
  logic               act;
  logic               step;
  logic               at_max;

  always_comb begin
    act    = cfg_q.low_level ? ~lvl_s : lvl_s;
    step   = run_q & act;
    at_max = (cnt_q == CNT_MAX);
    ovf_o  = step & act_d & at_max & ~cfg_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      run_q <= 1'b0;
      act_d <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_d <= act;
      if (cfg_wr) begin
        cfg_q <= cfg_new;
        run_q <= cfg_new.enable;
        cnt_q <= '0;
      end else if (step) begin
        if (!act_d) begin
          cnt_q <= CNT_ONE;
        end else if (at_max) begin
          cnt_q <= '0;
          if (!cfg_q.wrap) run_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + CNT_ONE;
        end
      end
    end
  end

  assign count_o = cnt_q;
  assign run_o   = run_q;
endmodule

// File: rtl/evt_status.sv
module evt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_i,
  input  logic rd_i,
  input  logic irq_en,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (ovf_i) flag_q <= 1'b1;
    else if (rd_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en;
endmodule

// File: rtl/evt_pulse_timer.sv
module evt_pulse_timer
  import evt_pkg::*;
#(
  parameter int COUNT_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_in,
  input  logic               cfg_wr,
  input  logic               cfg_enable,
  input  logic               cfg_low_level,
  input  logic               cfg_wrap,
  input  logic               irq_en,
  input  logic               stat_rd,
  output logic [COUNT_W-1:0] count_o,
  output logic               run_o,
  output logic               ovf_flag_o,
  output logic               irq_o
);
  logic     lvl_s;
  logic     ovf;
  evt_cfg_t cfg_new;

  assign cfg_new = '{enable: cfg_enable, low_level: cfg_low_level, wrap: cfg_wrap};

  evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ext_in), .q_o(lvl_s)
  );

  evt_core #(.COUNT_W(COUNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .lvl_s(lvl_s), .cfg_wr(cfg_wr), .cfg_new(cfg_new),
    .count_o(count_o), .run_o(run_o), .ovf_o(ovf)
  );

  evt_status u_stat (
    .clk(clk), .rst_n(rst_n), .ovf_i(ovf), .rd_i(stat_rd), .irq_en(irq_en),
    .flag_o(ovf_flag_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/evt_pulse_timer_chk.sv
module evt_pulse_timer_chk #(
  parameter int COUNT_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_wr,
  input logic               irq_en,
  input logic               stat_rd,
  input logic [COUNT_W-1:0] count_o,
  input logic               run_o,
  input logic               ovf_flag_o,
  input logic               irq_o
);
  // R2 R5: while running, the count only steps by one or restarts
  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && !cfg_wr) |=> ((count_o == $past(count_o) + COUNT_W'(1)) ||
                            (count_o <= COUNT_W'(1)) || $stable(count_o)));

  // R6: a stopped timer does not count
  assert_stopped_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_o && !cfg_wr) |=> $stable(count_o));

  // R6: a configuration write clears the count
  assert_wr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (count_o == '0));

  // R8: a stop not caused by a write leaves zero and a raised flag
  assert_stop_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(run_o) && !$past(cfg_wr)) |-> (count_o == '0 && ovf_flag_o));

  // R9: the flag is sticky until read
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag_o && !stat_rd) |=> ovf_flag_o);

  // R10: no interrupt while masked or without a flag
  assert_irq_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_en && ovf_flag_o));
endmodule

bind evt_pulse_timer evt_pulse_timer_chk #(.COUNT_W(COUNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .irq_en(irq_en), .stat_rd(stat_rd),
  .count_o(count_o), .run_o(run_o), .ovf_flag_o(ovf_flag_o), .irq_o(irq_o)
);

// File: tb/evt_pulse_timer_tb.sv
module evt_pulse_timer_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ext_in = 1'b0;
  logic         cfg_wr = 1'b0, cfg_enable = 1'b0, cfg_low_level = 1'b0, cfg_wrap = 1'b0;
  logic         irq_en = 1'b0, stat_rd = 1'b0;
  logic [W-1:0] count_o;
  logic         run_o, ovf_flag_o, irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  evt_pulse_timer #(.COUNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .cfg_wr(cfg_wr), .cfg_enable(cfg_enable),
    .cfg_low_level(cfg_low_level), .cfg_wrap(cfg_wrap), .irq_en(irq_en), .stat_rd(stat_rd),
    .count_o(count_o), .run_o(run_o), .ovf_flag_o(ovf_flag_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic configure(input bit en, input bit low, input bit wrap);
    @(negedge clk);
    cfg_enable = en; cfg_low_level = low; cfg_wrap = wrap; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // active level held for exactly n clock samples, then idle level
  task automatic pulse(input bit active, input int n);
    @(negedge clk);
    ext_in = active;
    idle(n);
    ext_in = ~active;
    idle(5);
  endtask

  task automatic read_flag();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  initial begin
    idle(3);
    // R1 reset state
    chk("R1 count", int'(count_o), 0);
    chk("R1 flag", int'(ovf_flag_o), 0);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 run", int'(run_o), 0);
    rst_n = 1'b1;
    idle(2);

    // R6 stopped timer ignores pulses
    pulse(1'b1, 7);
    chk("R6 disabled count", int'(count_o), 0);

    configure(1'b1, 1'b0, 1'b1);
    chk("R6 run after enable", int'(run_o), 1);

    // R2 R5 sweep of high pulses, each measured from zero
    for (int n = 1; n <= 40; n++) begin
      pulse(1'b1, n);
      chk("R2 R5 high width", int'(count_o), n);
    end
    // R4 hold
    idle(20);
    chk("R4 hold", int'(count_o), 40);
    pulse(1'b1, 3);
    chk("R5 restart shorter", int'(count_o), 3);

    // R6 disable write clears and stops
    configure(1'b0, 1'b0, 1'b1);
    chk("R6 clear on write", int'(count_o), 0);
    chk("R6 run cleared", int'(run_o), 0);
    pulse(1'b1, 9);
    chk("R6 ignored pulse", int'(count_o), 0);

    // R3 low-level sweep
    ext_in = 1'b1;
    idle(4);
    configure(1'b1, 1'b1, 1'b1);
    for (int n = 1; n <= 30; n++) begin
      pulse(1'b0, n);
      chk("R3 low width", int'(count_o), n);
    end
    idle(10);
    chk("R4 hold low mode", int'(count_o), 30);
    ext_in = 1'b0;
    idle(4);

    // R7 wrap mode overflow: 260 mod 256 = 4
    configure(1'b1, 1'b0, 1'b1);
    chk("R7 no flag before", int'(ovf_flag_o), 0);
    pulse(1'b1, 260);
    chk("R7 wrapped count", int'(count_o), 260 % (1 << W));
    chk("R7 run kept", int'(run_o), 1);
    chk("R9 flag set", int'(ovf_flag_o), 1);
    chk("R10 masked irq", int'(irq_o), 0);
    irq_en = 1'b1;
    idle(1);
    chk("R10 irq enabled", int'(irq_o), 1);
    idle(10);
    chk("R9 flag sticky", int'(ovf_flag_o), 1);
    read_flag();
    chk("R9 flag cleared", int'(ovf_flag_o), 0);
    chk("R10 irq cleared", int'(irq_o), 0);
    pulse(1'b1, 255);
    chk("R7 max no overflow", int'(count_o), 255);
    chk("R7 no flag at max", int'(ovf_flag_o), 0);

    // R8 stop mode overflow
    configure(1'b1, 1'b0, 1'b0);
    pulse(1'b1, 300);
    chk("R8 count zero", int'(count_o), 0);
    chk("R8 run cleared", int'(run_o), 0);
    chk("R8 flag set", int'(ovf_flag_o), 1);
    chk("R10 irq on", int'(irq_o), 1);
    pulse(1'b1, 6);
    chk("R8 stays stopped", int'(count_o), 0);
    configure(1'b1, 1'b0, 1'b0);
    pulse(1'b1, 6);
    chk("R8 resumes after enable", int'(count_o), 6);
    read_flag();
    chk("R9 read clears", int'(ovf_flag_o), 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule